// File: doc/BRIEF.md
# Fractional Slot Baud-Rate Generator

This block produces the 16x oversampling strobe that a UART transmitter and receiver share. It also produces a bit strobe that marks the end of each bit time. The source clock is one of two clock-enable streams: one from the peripheral clock and one from a divided PLL clock. A select input picks the stream. Each source event advances a period counter. An integer divisor sets the base length of every sample period.

A 16-bit slot mask gives fractional resolution. Inside one bit time a 4-bit slot index walks through the sixteen sample periods. When the mask bit addressed by the current index is set, that sample period gets one extra source event. The mean divide ratio therefore moves in steps of one sixteenth. The divisor and mask are captured only at a bit boundary, and also while the block is in reset or disabled. A bit that is already under way always keeps the timing it started with.

Top module: `frac_baud_gen`

## Requirements
- R1: Sample period `i` of a bit time lasts `div_int + 1 + slot_mask[i]` source events. Slot 0 is the first period after a bit tick, and bit `i` of `slot_mask` stretches slot `i`.
- R2: `bit_tick` is high only together with `samp_tick`, on every sixteenth sample tick. One bit time therefore spans `16*(div_int+1) + popcount(slot_mask)` source events.
- R3: `samp_tick` is high for exactly one clock at the end of each sample period.
- R4: The divisor is 16 bits wide and the largest value, 65535, works: a sample period then lasts 65536 source events, or 65537 if the slot bit is set.
- R5: `clk_sel` = 0 takes source events from `periph_ce`, and `clk_sel` = 1 takes them from `pll_ce`. Events on the unselected input have no effect.
- R6: A change of `div_int` or `slot_mask` during a bit time does not alter that bit time. The new value applies from the next bit time on.
- R7: While `en` is low, all counters are held at zero and no tick is produced. After `en` rises, the first sample tick appears `div_int + 1 + slot_mask[0]` clocks later when the selected source is active on every clock.
- R8: While `rst` (synchronous, active high) is asserted, both tick outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Simulation clock; every register samples on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run enable; low clears the counters |
| clk_sel | input | 1 | Source select: 0 peripheral, 1 PLL |
| periph_ce | input | 1 | Source event from the peripheral clock |
| pll_ce | input | 1 | Source event from the divided PLL clock |
| div_int | input | DIV_W (16) | Integer divisor |
| slot_mask | input | 16 | Per-slot stretch mask |
| samp_tick | output | 1 | One-clock strobe at 16x the baud rate |
| bit_tick | output | 1 | One-clock strobe at the end of each bit time |

## Verification
The bench builds the block with its defaults: a 16-bit divisor and sixteen slots. With these values the full divisor range and every mask bit position can be reached. The small divisors in the vector table keep whole bit times short, so each slot length can be compared one by one against its mask bit. A single sample period at divisor 65535 covers the top of the range without running a full bit time.

// File: rtl/fbg_pkg.sv
package fbg_pkg;
    localparam int unsigned SLOTS  = 16;
    localparam int unsigned SLOT_W = $clog2(SLOTS);

    typedef enum logic {
        SRC_PERIPH = 1'b0,
        SRC_PLL    = 1'b1
    } src_sel_e;

    typedef struct packed {
        logic period_end;
        logic bit_end;
    } tick_t;

    function automatic logic [SLOT_W-1:0] slot_next(input logic [SLOT_W-1:0] s);
        return (s == SLOT_W'(SLOTS - 1)) ? '0 : s + 1'b1;
    endfunction
endpackage

// File: rtl/fbg_src_sel.sv
module fbg_src_sel
    import fbg_pkg::*;
(
    input  logic clk_sel,
    input  logic periph_ce,
    input  logic pll_ce,
    output logic src_ce
);
    src_sel_e sel_q;
    always_comb begin
        sel_q = src_sel_e'(clk_sel);
        unique case (sel_q)
            SRC_PLL: src_ce = pll_ce;
            default: src_ce = periph_ce;
        endcase
    end
endmodule

// File: rtl/fbg_cfg_hold.sv
module fbg_cfg_hold #(
    parameter int unsigned DIV_W = 16,
    parameter int unsigned NSLOT = 16
) (
    input  logic             clk,
    input  logic             load,
    input  logic [DIV_W-1:0] div_in,
    input  logic [NSLOT-1:0] mask_in,
    output logic [DIV_W-1:0] div_q,
    output logic [NSLOT-1:0] mask_q
);
    always_ff @(posedge clk) begin
        if (load) begin
            div_q  <= div_in;
            mask_q <= mask_in;
        end
    end
endmodule

// File: rtl/fbg_period_cnt.sv
module fbg_period_cnt #(
    parameter int unsigned DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             step,
    input  logic [DIV_W-1:0] div,
    input  logic             stretch,
    output logic             period_end
);
    localparam int unsigned CNT_W = DIV_W + 1;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] last_val;

    always_comb begin
        last_val   = {1'b0, div} + CNT_W'(stretch);
        period_end = run && step && (cnt_q == last_val);
    end

    always_ff @(posedge clk) begin
        if (rst || !run)     cnt_q <= '0;
        else if (period_end) cnt_q <= '0;
        else if (step)       cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/fbg_slot_cnt.sv
module fbg_slot_cnt
    import fbg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic              adv,
    output logic [SLOT_W-1:0] slot,
    output logic              last
);
    always_comb last = (slot == SLOT_W'(SLOTS - 1));

    always_ff @(posedge clk) begin
        if (rst || !run) slot <= '0;
        else if (adv)    slot <= slot_next(slot);
    end
endmodule

// File: rtl/frac_baud_gen.sv
module frac_baud_gen
    import fbg_pkg::*;
#(
    parameter int unsigned DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             clk_sel,
    input  logic             periph_ce,
    input  logic             pll_ce,
    input  logic [DIV_W-1:0] div_int,
    input  logic [SLOTS-1:0] slot_mask,
    output logic             samp_tick,
    output logic             bit_tick
);
    logic              src_ce;
    logic [DIV_W-1:0]  div_q;
    logic [SLOTS-1:0]  mask_q;
    logic [SLOT_W-1:0] slot;
    logic              slot_last;
    logic              load;
    tick_t             nxt, tick_q;

    fbg_src_sel u_sel (
        .clk_sel  (clk_sel),
        .periph_ce(periph_ce),
        .pll_ce   (pll_ce),
        .src_ce   (src_ce)
    );

    fbg_period_cnt #(.DIV_W(DIV_W)) u_per (
        .clk       (clk),
        .rst       (rst),
        .run       (en),
        .step      (src_ce),
        .div       (div_q),
        .stretch   (mask_q[slot]),
        .period_end(nxt.period_end)
    );

    fbg_slot_cnt u_slot (
        .clk (clk),
        .rst (rst),
        .run (en),
        .adv (nxt.period_end),
        .slot(slot),
        .last(slot_last)
    );

    always_comb begin
        nxt.bit_end = nxt.period_end && slot_last;
        load        = rst || !en || nxt.bit_end;
    end

    fbg_cfg_hold #(.DIV_W(DIV_W), .NSLOT(SLOTS)) u_cfg (
        .clk    (clk),
        .load   (load),
        .div_in (div_int),
        .mask_in(slot_mask),
        .div_q  (div_q),
        .mask_q (mask_q)
    );

    always_ff @(posedge clk) begin
        if (rst || !en) tick_q <= '0;
        else            tick_q <= nxt;
    end

    assign samp_tick = tick_q.period_end;
    assign bit_tick  = tick_q.bit_end;
endmodule

// File: rtl/frac_baud_gen_chk.sv
module frac_baud_gen_chk
    import fbg_pkg::*;
#(
    parameter int unsigned DIV_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             en,
    input logic             clk_sel,
    input logic             periph_ce,
    input logic             pll_ce,
    input logic             samp_tick,
    input logic             bit_tick,
    input logic [DIV_W-1:0] div_q,
    input logic [SLOTS-1:0] mask_q
);
    logic [SLOT_W-1:0] seen_q;
    always_ff @(posedge clk) begin
        if (rst || !en)     seen_q <= '0;
        else if (samp_tick) seen_q <= seen_q + 1'b1;
    end

    assert_bit_needs_samp_R2: assert property (@(posedge clk) disable iff (rst)
        bit_tick |-> samp_tick);
    assert_bit_on_sixteenth_R2: assert property (@(posedge clk) disable iff (rst)
        (samp_tick && en) |-> (bit_tick == (seen_q == SLOT_W'(SLOTS - 1))));
    assert_quiet_when_off_R7: assert property (@(posedge clk) disable iff (rst)
        !en |=> (!samp_tick && !bit_tick));
    assert_no_src_no_tick_R5: assert property (@(posedge clk) disable iff (rst)
        !(clk_sel ? pll_ce : periph_ce) |=> !samp_tick);
    assert_cfg_at_boundary_R6: assert property (@(posedge clk) disable iff (rst)
        ($past(en) && !$past(rst) && !($stable(div_q) && $stable(mask_q))) |-> bit_tick);
endmodule

bind frac_baud_gen frac_baud_gen_chk #(.DIV_W(DIV_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .en       (en),
    .clk_sel  (clk_sel),
    .periph_ce(periph_ce),
    .pll_ce   (pll_ce),
    .samp_tick(samp_tick),
    .bit_tick (bit_tick),
    .div_q    (div_q),
    .mask_q   (mask_q)
);

// File: tb/frac_baud_gen_tb.sv
module frac_baud_gen_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WD_CYCLES  = 195000;

    typedef struct packed {
        logic [15:0] div;
        logic [15:0] mask;
        logic [31:0] span;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{16'd1, 16'h0000, 32'd32},
        '{16'd3, 16'h00FF, 32'd72},
        '{16'd2, 16'hFFFF, 32'd64},
        '{16'd5, 16'h8001, 32'd98},
        '{16'd1, 16'hAAAA, 32'd40},
        '{16'd7, 16'h0010, 32'd129}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en = 1'b0;
    logic        clk_sel = 1'b0;
    logic        periph_ce = 1'b1;
    logic        pll_ce = 1'b0;
    logic [15:0] div_int = 16'd1;
    logic [15:0] slot_mask = 16'h0;
    logic        samp_tick, bit_tick;

    int cyc = 0;
    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    frac_baud_gen u_dut (
        .clk(clk), .rst(rst), .en(en), .clk_sel(clk_sel),
        .periph_ce(periph_ce), .pll_ce(pll_ce),
        .div_int(div_int), .slot_mask(slot_mask),
        .samp_tick(samp_tick), .bit_tick(bit_tick)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_tick(input bit want_bit, output int t);
        forever begin
            @(negedge clk);
            if (want_bit ? bit_tick : samp_tick) begin
                t = cyc;
                return;
            end
        end
    endtask

    task automatic count_ticks(input int n, output int seen);
        seen = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (samp_tick || bit_tick) seen++;
        end
    endtask

    task automatic restart(input logic [15:0] d, input logic [15:0] m);
        @(negedge clk);
        en = 1'b0;
        div_int = d;
        slot_mask = m;
        @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected 0 cycles left", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int seen, t0, t1, t2, c0;
        // R8: reset keeps ticks low even with enable high
        en = 1'b1;
        count_ticks(40, seen);
        check("R8 ticks during reset", seen, 0);
        @(negedge clk);
        rst = 1'b0;
        en = 1'b0;

        // R7: disabled block stays quiet
        count_ticks(100, seen);
        check("R7 ticks while disabled", seen, 0);

        // R1/R2/R3/R7: vector table
        foreach (VECS[v]) begin
            restart(VECS[v].div, VECS[v].mask);
            en = 1'b1;
            c0 = cyc;
            wait_tick(1'b0, t1);
            check("R7 first sample delay", t1 - c0,
                  int'(VECS[v].div) + 1 + int'(VECS[v].mask[0]));
            @(negedge clk);
            check("R3 sample tick width", int'(samp_tick), 0);
            wait_tick(1'b1, t0);
            t1 = t0;
            for (int s = 0; s < 16; s++) begin
                wait_tick(1'b0, t2);
                check("R1 slot length", t2 - t1,
                      int'(VECS[v].div) + 1 + int'(VECS[v].mask[s]));
                check("R2 bit tick on slot", int'(bit_tick), (s == 15) ? 1 : 0);
                t1 = t2;
            end
            check("R2 bit span", t1 - t0, int'(VECS[v].span));
        end

        // R6: mid-bit change takes effect at next bit
        restart(16'd2, 16'h0000);
        en = 1'b1;
        wait_tick(1'b1, t0);
        repeat (10) @(negedge clk);
        div_int = 16'd4;
        slot_mask = 16'h000F;
        wait_tick(1'b1, t1);
        check("R6 bit in progress kept", t1 - t0, 48);
        wait_tick(1'b1, t2);
        check("R6 new config next bit", t2 - t1, 84);

        // R5: source select
        restart(16'd1, 16'h0000);
        clk_sel = 1'b1;
        periph_ce = 1'b1;
        pll_ce = 1'b0;
        en = 1'b1;
        count_ticks(100, seen);
        check("R5 unselected periph ignored", seen, 0);
        @(negedge clk);
        pll_ce = 1'b1;
        periph_ce = 1'b0;
        wait_tick(1'b1, t0);
        wait_tick(1'b1, t1);
        check("R5 pll source span", t1 - t0, 32);
        @(negedge clk);
        clk_sel = 1'b0;
        count_ticks(100, seen);
        check("R5 unselected pll ignored", seen, 0);

        // R4: largest divisor
        restart(16'hFFFF, 16'h0001);
        periph_ce = 1'b1;
        en = 1'b1;
        c0 = cyc;
        wait_tick(1'b0, t1);
        check("R4 max divisor period", t1 - c0, 65537);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule